// File: doc/BRIEF.md
# Memory-Mapped FIFO Port

This block puts a FIFO behind a small register window so that a processor or a DMA engine can move words with plain single-word reads and writes. The data register sits at a fixed address. A DMA engine can therefore stream words to or from it without incrementing its address. A status word carries the empty, full and error flags. A control word holds an interrupt enable and a stall-mode enable. Two further registers report how many words are stored and how many slots are still free.

The FIFO model is built into the block. A build-time parameter sets which side the bus sits on:

- **Read side** (`WRITE_DIR = 0`): the far side pushes words in and the bus pops them.
- **Write side** (`WRITE_DIR = 1`): the bus pushes words in and the far side pops them.

The block works out occupancy as a count one bit wider than the FIFO address, so a completely full FIFO can be represented. It does this by putting the FIFO's full flag above its narrow used-words bus. A second parameter handles a FIFO that stops one word short of its nominal depth. With that parameter set, the full flag is dropped from the count and the free-slot figure is computed from the reduced capacity.

When stall mode is off, a data access the FIFO cannot serve completes at once and latches an error flag. When stall mode is on, the block holds the bus master on `bus_wait` until the access can be served.

Top module: `mmfifo_port`

## Requirements
- R1: After reset, the status word reads 1 (empty set, full clear, error clear), the control word reads 0, the used count reads 0, the free count reads the capacity, and `irq` is low.
- R2: Data words leave the FIFO in the order they entered. A bus read returns its value on `bus_rdata` one clock after the cycle in which the read is accepted (`bus_cs` and `bus_rd` high, `bus_wait` low).
- R3: Each accepted bus access to the data register (address 0) that the FIFO serves raises `fifo_rdreq` (pop) or `fifo_wrreq` (push) for exactly that one cycle. Accesses to other addresses raise neither strobe.
- R4: The used count at address 3 is `ADDR_W+1` bits wide. With `SHORT_BY_ONE = 0`, a full FIFO of depth 2^`ADDR_W` reads exactly 2^`ADDR_W`, and the free count at address 4 reads 0.
- R5: With `SHORT_BY_ONE = 1`, the capacity is 2^`ADDR_W` − 1. The full flag sets at that many words, the used count never includes the full flag, and free = capacity − used.
- R6: The status word at address 1 has empty in bit 0, full in bit 1 and the sticky error in bit 2. Empty and full are never set together.
- R7: With stall mode off, a bus data read from an empty FIFO returns 0, sets the error flag, raises no pop strobe and does not assert `bus_wait`.
- R8: With stall mode off, a bus data write to a full FIFO is dropped, sets the error flag and does not assert `bus_wait`. A far-side push into a full FIFO is also dropped.
- R9: The error flag stays set until a write to the status word with bit 2 equal to 1. A status write with bit 2 equal to 0 leaves it set.
- R10: With control bit 1 set (stall mode), `bus_wait` is held high during a bus data read while the FIFO is empty, or during a bus data write while it is full. The access then completes normally once the far side makes room or supplies data, and it does not set the error flag. `bus_wait` is never high while stall mode is off.
- R11: `irq` is high when control bit 0 is set and, on the read side, the FIFO is not empty, or, on the write side, the FIFO is not full.
- R12: The address map is: 0 data, 1 status, 2 control, 3 used count, 4 free count. The control word reads back bits [1:0] as written. Reads of addresses 5 to 7 return 0.
- R13: A bus data access against the configured direction has no effect on the FIFO and raises no strobe: a write on the read side, or a read on the write side (which returns 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Bus select for this block |
| bus_rd | input | 1 | Bus read request |
| bus_wr | input | 1 | Bus write request |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Registered read data, one cycle after acceptance |
| bus_wait | output | 1 | Stall for the bus master (stall mode only) |
| irq | output | 1 | Level interrupt gated by control bit 0 |
| fifo_wrreq | output | 1 | Push strobe into the FIFO |
| fifo_rdreq | output | 1 | Pop strobe out of the FIFO |
| far_push | input | 1 | Far-side push (read side only) |
| far_wdata | input | DATA_W | Far-side push data |
| far_pop | input | 1 | Far-side pop (write side only) |
| far_rdata | output | DATA_W | Word at the FIFO head |

## Verification
The assertions check the following on every cycle:
- the FIFO is never pushed while full or popped while empty;
- the stored count never exceeds the capacity;
- empty and full never hold together;
- `bus_wait` only rises in stall mode;
- the error flag only falls on a clearing write.

Some behaviour can only be shown by the bench scenarios, which run on one read-side instance and one write-side instance with the reduced capacity:
- ordering and one-cycle read latency;
- the exact used and free figures at full for both capacity options;
- the return value of an empty read;
- dropped writes;
- how long a stalled access waits and that it then completes.

// File: rtl/mmfifo_pkg.sv
// Package: register addresses and bit positions shared by the FIFO port.
// Assumes a 3-bit register address bus.
package mmfifo_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_DATA = 3'd0;
    localparam logic [REG_AW-1:0] A_STAT = 3'd1;
    localparam logic [REG_AW-1:0] A_CTRL = 3'd2;
    localparam logic [REG_AW-1:0] A_USED = 3'd3;
    localparam logic [REG_AW-1:0] A_FREE = 3'd4;

    localparam int ST_EMPTY = 0;
    localparam int ST_FULL  = 1;
    localparam int ST_ERR   = 2;

    localparam int CT_IRQ   = 0;
    localparam int CT_STALL = 1;

    typedef struct packed {
        logic stall_en;
        logic irq_en;
    } ctrl_t;
endpackage

// File: rtl/mmfifo_store.sv
// Module: FIFO storage model with a narrow used-words bus and a full flag,
// in the manner of a typical FIFO macro.
// Assumes: the caller never pushes while full and never pops while empty.
// The head word is visible combinationally (show-ahead).
module mmfifo_store #(
    parameter int DW    = 32,
    parameter int AW    = 4,
    parameter int SHORT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [AW-1:0] usedw,
    output logic          full,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = AW + 1;
    localparam logic [CW-1:0] CAP = CW'(DEPTH - SHORT);

    logic [AW-1:0]       wp_q, rp_q;
    logic [CW-1:0]       cnt_q;
    logic [DEPTH*DW-1:0] flat;

    // One storage word per slot, written when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DW-1:0] word_q;
        always_ff @(posedge clk) begin
            if (push && wp_q == AW'(g)) word_q <= wdata;
        end
        assign flat[g*DW +: DW] = word_q;
    end

    // Pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = flat[rp_q*DW +: DW];
    assign usedw = cnt_q[AW-1:0];
    assign full  = (cnt_q == CAP);
    assign empty = (cnt_q == '0);

    AST_NO_PUSH_FULL:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);   // R8
    AST_NO_POP_EMPTY:  assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);  // R7
    AST_COUNT_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CAP);    // R5
    AST_FLAGS_EXCL:    assert property (@(posedge clk) disable iff (!rst_n) !(full && empty)); // R6
endmodule

// File: rtl/mmfifo_level.sv
// Module: forms the exact used count and the free-slot count from the
// FIFO's narrow used-words bus and its full flag.
// Assumes: with SHORT = 0 the narrow bus wraps to zero at full. With
// SHORT = 1 it never wraps, so the full flag must not be added.
module mmfifo_level #(
    parameter int AW    = 4,
    parameter int SHORT = 0
) (
    input  logic [AW-1:0] usedw,
    input  logic          full,
    output logic [AW:0]   used,
    output logic [AW:0]   free
);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] CAP = CW'((1 << AW) - SHORT);
    localparam logic FULL_AS_MSB  = (SHORT == 0);

    // Full flag goes above the narrow bus only when capacity is a power of two.
    always_comb begin
        used = {full & FULL_AS_MSB, usedw};
        free = CAP - used;
    end
endmodule

// File: rtl/mmfifo_regs.sv
// Module: bus register file and access control for the FIFO port.
// Decodes the address, generates push/pop requests and the stall, keeps
// the control word and the sticky error flag, and registers read data.
// Assumes a single-cycle bus: an access is accepted in any cycle with
// select and read or write high and bus_wait low.
module mmfifo_regs
    import mmfifo_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 4,
    parameter int WRITE_DIR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     head,
    input  logic              empty,
    input  logic              full,
    input  logic [AW:0]       used,
    input  logic [AW:0]       free,
    output logic [DW-1:0]     rdata,
    output logic              bus_wait,
    output logic              bus_pop,
    output logic              bus_push,
    output logic              irq
);
    localparam logic IS_WR = (WRITE_DIR != 0);

    ctrl_t         ctrl_q;
    logic          err_q;
    logic [DW-1:0] rdata_q;
    logic          data_sel, rd_acc, wr_acc, under, over, err_clr;

    // Stall and acceptance decode.
    always_comb begin
        data_sel = cs && addr == A_DATA;
        bus_wait = ctrl_q.stall_en && data_sel &&
                   ((!IS_WR && rd && empty) || (IS_WR && wr && full));
        rd_acc   = cs && rd && !bus_wait;
        wr_acc   = cs && wr && !bus_wait;
        bus_pop  = !IS_WR && rd_acc && data_sel && !empty;
        bus_push =  IS_WR && wr_acc && data_sel && !full;
        under    = !IS_WR && rd_acc && data_sel && empty;
        over     =  IS_WR && wr_acc && data_sel && full;
        err_clr  = wr_acc && addr == A_STAT && wdata[ST_ERR];
    end

    // Control word and sticky error flag (a set wins over a clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wr_acc && addr == A_CTRL) begin
                ctrl_q.irq_en   <= wdata[CT_IRQ];
                ctrl_q.stall_en <= wdata[CT_STALL];
            end
            if (under || over)  err_q <= 1'b1;
            else if (err_clr)   err_q <= 1'b0;
        end
    end

    // Registered read data, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_acc) begin
            case (addr)
                A_DATA:  rdata_q <= bus_pop ? head : '0;
                A_STAT:  rdata_q <= DW'({err_q, full, empty});
                A_CTRL:  rdata_q <= DW'(ctrl_q);
                A_USED:  rdata_q <= DW'(used);
                A_FREE:  rdata_q <= DW'(free);
                default: rdata_q <= '0;
            endcase
        end
    end

    assign rdata = rdata_q;
    assign irq   = ctrl_q.irq_en && (IS_WR ? !full : !empty);

    AST_WAIT_NEEDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> ctrl_q.stall_en);                                     // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clr) |=> err_q);                                    // R9
    AST_NO_WAIT_OFF_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && addr != A_DATA) |-> !bus_wait);                             // R12
endmodule

// File: rtl/mmfifo_port.sv
// Module: top of the memory-mapped FIFO port.
// Connects the register file, the level logic and the FIFO model. The
// FIFO is fed from the bus on the write side (WRITE_DIR = 1) or from the
// far side on the read side (WRITE_DIR = 0).
// Assumes: DATA_W is wider than ADDR_W + 1 so that the counts fit in a word.
module mmfifo_port
    import mmfifo_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 4,
    parameter int SHORT_BY_ONE = 0,
    parameter int WRITE_DIR    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_wait,
    output logic              irq,
    output logic              fifo_wrreq,
    output logic              fifo_rdreq,
    input  logic              far_push,
    input  logic [DATA_W-1:0] far_wdata,
    input  logic              far_pop,
    output logic [DATA_W-1:0] far_rdata
);
    localparam logic IS_WR = (WRITE_DIR != 0);

    logic [DATA_W-1:0] head, st_wdata;
    logic [ADDR_W-1:0] usedw;
    logic [ADDR_W:0]   used, free;
    logic              full, empty, bus_pop, bus_push, push, pop;

    // Route the push/pop sources by direction; far-side requests are gated by the flags.
    always_comb begin
        push     = IS_WR ? bus_push : (far_push && !full);
        pop      = IS_WR ? (far_pop && !empty) : bus_pop;
        st_wdata = IS_WR ? bus_wdata : far_wdata;
    end

    mmfifo_store #(.DW(DATA_W), .AW(ADDR_W), .SHORT(SHORT_BY_ONE)) store_i (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(st_wdata), .pop(pop),
        .head(head), .usedw(usedw), .full(full), .empty(empty)
    );

    mmfifo_level #(.AW(ADDR_W), .SHORT(SHORT_BY_ONE)) level_i (
        .usedw(usedw), .full(full), .used(used), .free(free)
    );

    mmfifo_regs #(.DW(DATA_W), .AW(ADDR_W), .WRITE_DIR(WRITE_DIR)) regs_i (
        .clk(clk), .rst_n(rst_n), .cs(bus_cs), .rd(bus_rd), .wr(bus_wr),
        .addr(bus_addr), .wdata(bus_wdata), .head(head), .empty(empty),
        .full(full), .used(used), .free(free), .rdata(bus_rdata),
        .bus_wait(bus_wait), .bus_pop(bus_pop), .bus_push(bus_push), .irq(irq)
    );

    assign fifo_wrreq = push;
    assign fifo_rdreq = pop;
    assign far_rdata  = head;

    AST_STROBE_EXCL_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_pop && bus_push));                                           // R3
endmodule

// File: tb/mmfifo_port_tb.sv
// Bench: directed scenarios on a read-side instance (dut_i, depth 16, full
// capacity) and a write-side instance (dut_w, depth 8, one word short).
module mmfifo_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        cs [2];
    logic        rd [2];
    logic        wr [2];
    logic [2:0]  addr [2];
    logic [31:0] wdat [2];
    logic [31:0] rdat [2];
    logic        waitr [2];
    logic        irq [2];
    logic        wrreq [2];
    logic        rdreq [2];
    logic        fpush [2];
    logic [31:0] fwdat [2];
    logic        fpop [2];
    logic [31:0] frdat [2];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    mmfifo_port #(.DATA_W(32), .ADDR_W(4), .SHORT_BY_ONE(0), .WRITE_DIR(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs(cs[0]), .bus_rd(rd[0]), .bus_wr(wr[0]),
        .bus_addr(addr[0]), .bus_wdata(wdat[0]), .bus_rdata(rdat[0]), .bus_wait(waitr[0]),
        .irq(irq[0]), .fifo_wrreq(wrreq[0]), .fifo_rdreq(rdreq[0]), .far_push(fpush[0]),
        .far_wdata(fwdat[0]), .far_pop(fpop[0]), .far_rdata(frdat[0])
    );

    mmfifo_port #(.DATA_W(32), .ADDR_W(3), .SHORT_BY_ONE(1), .WRITE_DIR(1)) dut_w (
        .clk(clk), .rst_n(rst_n), .bus_cs(cs[1]), .bus_rd(rd[1]), .bus_wr(wr[1]),
        .bus_addr(addr[1]), .bus_wdata(wdat[1]), .bus_rdata(rdat[1]), .bus_wait(waitr[1]),
        .irq(irq[1]), .fifo_wrreq(wrreq[1]), .fifo_rdreq(rdreq[1]), .far_push(fpush[1]),
        .far_wdata(fwdat[1]), .far_pop(fpop[1]), .far_rdata(frdat[1])
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Bus read: returns data, stall cycles and the pop strobe seen at acceptance.
    task automatic bus_read(input int u, input logic [2:0] a, output logic [31:0] d,
                            output int waits, output logic strobe);
        @(negedge clk);
        cs[u] = 1'b1; rd[u] = 1'b1; addr[u] = a;
        waits = 0;
        #1;
        while (waitr[u]) begin
            waits++;
            @(negedge clk); #1;
        end
        strobe = rdreq[u];
        @(posedge clk); #1;
        cs[u] = 1'b0; rd[u] = 1'b0;
        d = rdat[u];
    endtask

    // Bus write: returns stall cycles and the push strobe seen at acceptance.
    task automatic bus_write(input int u, input logic [2:0] a, input logic [31:0] v,
                             output int waits, output logic strobe);
        @(negedge clk);
        cs[u] = 1'b1; wr[u] = 1'b1; addr[u] = a; wdat[u] = v;
        waits = 0;
        #1;
        while (waitr[u]) begin
            waits++;
            @(negedge clk); #1;
        end
        strobe = wrreq[u];
        @(posedge clk); #1;
        cs[u] = 1'b0; wr[u] = 1'b0;
    endtask

    task automatic far_put(input int u, input logic [31:0] v);
        @(negedge clk);
        fpush[u] = 1'b1; fwdat[u] = v;
        @(negedge clk);
        fpush[u] = 1'b0;
    endtask

    task automatic far_take(input int u, output logic [31:0] v);
        @(negedge clk);
        v = frdat[u];
        fpop[u] = 1'b1;
        @(negedge clk);
        fpop[u] = 1'b0;
    endtask

    task automatic rd_reg(input int u, input logic [2:0] a, output logic [31:0] d);
        int w; logic s;
        bus_read(u, a, d, w, s);
    endtask

    task automatic wr_reg(input int u, input logic [2:0] a, input logic [31:0] v);
        int w; logic s;
        bus_write(u, a, v, w, s);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd_reg(0, 3'd1, d); check("R1 status after reset", d, 32'h1);
        rd_reg(0, 3'd2, d); check("R1 control after reset", d, 32'h0);
        rd_reg(0, 3'd3, d); check("R1 used after reset", d, 32'd0);
        rd_reg(0, 3'd4, d); check("R1 free after reset", d, 32'd16);
        check("R1 irq after reset", {31'b0, irq[0]}, 32'h0);
        rd_reg(1, 3'd4, d); check("R1 R5 free after reset (short)", d, 32'd7);
    endtask

    task automatic t_map();
        logic [31:0] d;
        for (int a = 5; a < 8; a++) begin
            rd_reg(0, 3'(a), d); check("R12 unmapped read", d, 32'h0);
        end
        wr_reg(0, 3'd2, 32'hFFFF_FFFF);
        rd_reg(0, 3'd2, d); check("R12 control readback", d, 32'h3);
        wr_reg(0, 3'd2, 32'h0);
    endtask

    task automatic t_order();
        logic [31:0] d; int w; logic s;
        far_put(0, 32'h1111); far_put(0, 32'h2222); far_put(0, 32'h3333);
        rd_reg(0, 3'd3, d); check("R4 used 3", d, 32'd3);
        rd_reg(0, 3'd4, d); check("R4 free 13", d, 32'd13);
        bus_read(0, 3'd1, d, w, s); check("R3 no strobe on status read", {31'b0, s}, 32'h0);
        bus_read(0, 3'd0, d, w, s); check("R2 first word", d, 32'h1111);
        check("R3 pop strobe", {31'b0, s}, 32'h1);
        bus_read(0, 3'd0, d, w, s); check("R2 second word", d, 32'h2222);
        bus_read(0, 3'd0, d, w, s); check("R2 third word", d, 32'h3333);
        // one-cycle latency: data valid in the cycle after acceptance, then held
        @(negedge clk); check("R2 data held after read", rdat[0], 32'h3333);
    endtask

    task automatic t_underflow();
        logic [31:0] d; int w; logic s;
        bus_read(0, 3'd0, d, w, s);
        check("R7 empty read returns 0", d, 32'h0);
        check("R7 no wait", 32'(w), 32'd0);
        check("R7 no pop strobe", {31'b0, s}, 32'h0);
        rd_reg(0, 3'd1, d); check("R6 R7 status empty+err", d, 32'h5);
        wr_reg(0, 3'd1, 32'h3);
        rd_reg(0, 3'd1, d); check("R9 err kept when bit2 is 0", d, 32'h5);
        wr_reg(0, 3'd1, 32'h4);
        rd_reg(0, 3'd1, d); check("R9 err cleared", d, 32'h1);
    endtask

    task automatic t_fill_read_side();
        logic [31:0] d; int w; logic s;
        for (int i = 0; i < 16; i++) far_put(0, 32'h100 + 32'(i));
        rd_reg(0, 3'd1, d); check("R6 status full", d, 32'h2);
        rd_reg(0, 3'd3, d); check("R4 used at full", d, 32'd16);
        rd_reg(0, 3'd4, d); check("R4 free at full", d, 32'd0);
        far_put(0, 32'hDEAD);
        rd_reg(0, 3'd3, d); check("R8 far push dropped", d, 32'd16);
        bus_write(0, 3'd0, 32'hBEEF, w, s);
        check("R13 bus write on read side no strobe", {31'b0, s}, 32'h0);
        rd_reg(0, 3'd3, d); check("R13 used unchanged", d, 32'd16);
        wr_reg(0, 3'd2, 32'h1);
        check("R11 irq when not empty", {31'b0, irq[0]}, 32'h1);
        for (int i = 0; i < 16; i++) begin
            bus_read(0, 3'd0, d, w, s);
            check("R2 drain order", d, 32'h100 + 32'(i));
        end
        @(negedge clk);
        check("R11 irq low when empty", {31'b0, irq[0]}, 32'h0);
        wr_reg(0, 3'd2, 32'h0);
    endtask

    task automatic t_stall_read();
        logic [31:0] d; int w; logic s;
        wr_reg(0, 3'd2, 32'h2);
        fork
            bus_read(0, 3'd0, d, w, s);
            begin
                repeat (3) @(negedge clk);
                fpush[0] = 1'b1; fwdat[0] = 32'h7777;
                @(negedge clk);
                fpush[0] = 1'b0;
            end
        join
        check("R10 read stalled", 32'(w >= 3), 32'd1);
        check("R10 stalled read data", d, 32'h7777);
        check("R10 R3 stalled read strobe", {31'b0, s}, 32'h1);
        rd_reg(0, 3'd1, d); check("R10 no error after stall", d, 32'h1);
        wr_reg(0, 3'd2, 32'h0);
    endtask

    task automatic t_write_side();
        logic [31:0] d; int w; logic s;
        wr_reg(1, 3'd2, 32'h1);
        check("R11 write side irq when not full", {31'b0, irq[1]}, 32'h1);
        for (int i = 0; i < 7; i++) begin
            bus_write(1, 3'd0, 32'hA0 + 32'(i), w, s);
            check("R3 push strobe", {31'b0, s}, 32'h1);
        end
        rd_reg(1, 3'd1, d); check("R5 full at capacity-1", d, 32'h2);
        rd_reg(1, 3'd3, d); check("R5 used at full", d, 32'd7);
        rd_reg(1, 3'd4, d); check("R5 free at full", d, 32'd0);
        check("R11 write side irq low when full", {31'b0, irq[1]}, 32'h0);
        bus_write(1, 3'd0, 32'hEE, w, s);
        check("R8 overflow no wait", 32'(w), 32'd0);
        check("R8 overflow no strobe", {31'b0, s}, 32'h0);
        rd_reg(1, 3'd1, d); check("R8 status full+err", d, 32'h6);
        bus_read(1, 3'd0, d, w, s);
        check("R13 read on write side returns 0", d, 32'h0);
        check("R13 no pop strobe", {31'b0, s}, 32'h0);
        for (int i = 0; i < 7; i++) begin
            far_take(1, d);
            check("R2 write side order", d, 32'hA0 + 32'(i));
        end
        rd_reg(1, 3'd3, d); check("R8 dropped word not stored", d, 32'd0);
        wr_reg(1, 3'd1, 32'h4);
        wr_reg(1, 3'd2, 32'h0);
    endtask

    task automatic t_stall_write();
        logic [31:0] d; int w; logic s;
        wr_reg(1, 3'd2, 32'h2);
        for (int i = 0; i < 7; i++) wr_reg(1, 3'd0, 32'hC0 + 32'(i));
        fork
            bus_write(1, 3'd0, 32'h55, w, s);
            begin
                repeat (3) @(negedge clk);
                fpop[1] = 1'b1;
                @(negedge clk);
                fpop[1] = 1'b0;
            end
        join
        check("R10 write stalled", 32'(w >= 3), 32'd1);
        check("R10 stalled write strobe", {31'b0, s}, 32'h1);
        rd_reg(1, 3'd1, d); check("R10 full, no error", d, 32'h2);
        for (int i = 1; i < 7; i++) far_take(1, d);
        far_take(1, d); check("R10 stalled word stored last", d, 32'h55);
        wr_reg(1, 3'd2, 32'h0);
    endtask

    initial begin
        for (int u = 0; u < 2; u++) begin
            cs[u] = 0; rd[u] = 0; wr[u] = 0; addr[u] = '0; wdat[u] = '0;
            fpush[u] = 0; fwdat[u] = '0; fpop[u] = 0;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_map();
        t_order();
        t_underflow();
        t_fill_read_side();
        t_stall_read();
        t_write_side();
        t_stall_write();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule